// File: doc/BRIEF.md
# UART Control and Status Register Front End

This block is the software-visible face of a serial port controller. A host issues single-beat accesses carrying an address, a byte count, a write flag and sixteen bits of write data. The block keeps the controller's configuration registers (baud divisor halves, global control, line control, modem control, scratch) and its interrupt-enable mask. It also keeps the two sticky status words, which record line conditions and modem-line changes. Every accepted access gets a one-cycle acknowledge with read data in the following cycle. A rejected access instead gets a one-cycle error, with a second flag that tells a width fault from an unmapped address.

The shifter, the baud-rate generator and the receive path sit outside. They reach this block only through strobes that set status bits, a push of a received byte, and the live clear-to-send level. In the other direction, a write to the transmit holding register hands the byte to the shifter with a one-cycle load pulse. When the transmit-empty interrupt is enabled, the same write also emits a transmit event pulse.

Top module: `uart_reg_file`

## Requirements
- R1: An access whose byte count is not 2 produces, one cycle later, error=1 and width-error=1 with no acknowledge, and changes no register and no output.
- R2: The width check comes before address decode: a wrongly sized access to an unmapped address still reports width-error=1.
- R3: Registers sit at byte offsets 0x00 (transmit holding), 0x04 (receive buffer), 0x08 (enable set), 0x0C (enable clear), 0x10 (line status), 0x14 (modem status), 0x18 (divisor low), 0x1C (divisor high), 0x20 (global control), 0x24 (line control), 0x28 (modem control) and 0x2C (scratch). A correctly sized access elsewhere, or one not 4-byte aligned, gives error=1, width-error=0 and no acknowledge. An accepted access gives an acknowledge one cycle later, never together with error.
- R4: A write to 0x08 ORs the low byte into the interrupt-enable mask; reads of 0x08 or 0x0C return the mask, which also drives the enable output.
- R5: A write to 0x0C clears every mask bit whose written bit is one and leaves the other bits unchanged.
- R6: Line status bits are: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 transmit finished. Writing one clears bits 1 to 5; bit 0 ignores writes.
- R7: In modem status, bit 0 (clear-to-send changed) is cleared by writing one. Bit 4 shows the clear-to-send level registered one cycle, and ignores writes.
- R8: A hardware set strobe for a line or modem status bit wins over a software clear of the same bit in the same cycle.
- R9: A write to 0x00 drives the low byte on the transmit byte output and a one-cycle load pulse in the next cycle. An event pulse comes in that same cycle only if enable mask bit 1 was set. Reading 0x00 returns the last byte handed over.
- R10: Writes to 0x04 are ignored. A received-byte push stores the byte and sets data ready; a read of 0x04 returns the byte and clears data ready.
- R11: The six plain registers (0x18 to 0x2C) store the low 8 bits of a write. All reads return 0 in bits 15:8, and the divisor output is {high, low}.
- R12: After synchronous reset, every register, output pulse and response flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access accepted (one cycle after request) |
| bus_err | output | 1 | Access rejected (one cycle after request) |
| bus_err_width | output | 1 | Rejection was a width fault |
| tx_byte | output | 8 | Byte handed to the transmitter |
| tx_load | output | 1 | One-cycle pulse: tx_byte is new |
| tx_event | output | 1 | One-cycle transmit interrupt event |
| rx_push | input | 1 | Receive path delivers a byte |
| rx_byte | input | 8 | Received byte |
| stat_line_set | input | 6 | Per-bit set strobes for line status |
| stat_cts_chg | input | 1 | Set strobe for clear-to-send changed |
| cts_level | input | 1 | Live clear-to-send level |
| cfg_divisor | output | 16 | Baud divisor {high, low} |
| cfg_gctl | output | 8 | Global control register |
| cfg_lcr | output | 8 | Line control register |
| cfg_mcr | output | 8 | Modem control register |
| irq_enable | output | 8 | Interrupt-enable mask |

## Verification
Two functions can meet in one cycle: a hardware strobe setting a status bit, and a software write-one clear of that status word. The bench raises stat_line_set or stat_cts_chg in the same cycle as a write-one to the line or modem status register. Some of the written ones fall on the strobed bits and some on other set bits. A following read must show the strobed bits still set and only the other bits cleared. The same precedence is also checked cycle by cycle by assertions on the stored status bits.

// File: rtl/uart_regs_pkg.sv
// Shared definitions for the serial-port register front end: register
// selector values (index = byte offset / 4), status bit positions and the
// decoded access record passed between the sub-blocks.
package uart_regs_pkg;

    localparam int DATA_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 4;
    localparam int NUM_REGS   = 12;
    localparam int NUM_PLAIN  = 6;
    localparam int LINE_BITS  = 6;

    // Register selector; the order is the address map (offset = 4 * index).
    typedef enum logic [SEL_W-1:0] {
        SEL_TX_HOLD  = 4'd0,
        SEL_RX_BUF   = 4'd1,
        SEL_IE_SET   = 4'd2,
        SEL_IE_CLR   = 4'd3,
        SEL_LINE     = 4'd4,
        SEL_MODEM    = 4'd5,
        SEL_DIV_LO   = 4'd6,
        SEL_DIV_HI   = 4'd7,
        SEL_GCTL     = 4'd8,
        SEL_LCTL     = 4'd9,
        SEL_MCTL     = 4'd10,
        SEL_SCRATCH  = 4'd11
    } reg_sel_e;

    // First plain (directly written) register; the plain ones are contiguous.
    localparam int PLAIN_BASE = 6;

    // Line status bit positions.
    localparam int LS_READY   = 0;
    localparam int LS_OVERRUN = 1;
    localparam int LS_PARITY  = 2;
    localparam int LS_FRAMING = 3;
    localparam int LS_BREAK   = 4;
    localparam int LS_TX_DONE = 5;
    localparam logic [BYTE_W-1:0] LINE_W1C_MASK = 8'h3E;

    // Modem status bit positions.
    localparam int MS_CTS_CHG = 0;
    localparam int MS_CTS     = 4;

    // Interrupt-enable bit that gates the transmit event.
    localparam int IE_TX_EMPTY = 1;

    // One decoded, legal register access (valid only if width and map passed).
    typedef struct packed {
        logic                valid;
        logic                we;
        reg_sel_e            sel;
        logic [BYTE_W-1:0]   wdata;
    } reg_access_t;

endpackage

// File: rtl/uart_reg_decode.sv
// Access qualifier and address decoder.
// Checks the access width first, then the address map, and emits a decoded
// access record plus one-cycle error indications (combinational).
// Assumes ADDR_W >= 6 so the selector index fits in the offset field.
module uart_reg_decode
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int SIZE_W       = 3,
    parameter int ACCESS_BYTES = 2
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] wdata,
    output reg_access_t       acc,
    output logic              width_err,
    output logic              map_err
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             size_ok;
    logic             aligned;
    logic             in_range;
    logic             unused_hi;

    // Qualify width, alignment and range of the incoming access.
    always_comb begin
        idx      = addr[ADDR_W-1:2];
        size_ok  = (32'(size) == ACCESS_BYTES);
        aligned  = (addr[1:0] == 2'b00);
        in_range = (32'(idx) < NUM_REGS);
    end

    // Width fault outranks the address fault.
    always_comb begin
        width_err = req && !size_ok;
        map_err   = req && size_ok && !(aligned && in_range);
    end

    // Build the decoded access record for legal accesses.
    always_comb begin
        acc.valid = req && size_ok && aligned && in_range;
        acc.we    = we;
        acc.sel   = reg_sel_e'(idx[SEL_W-1:0]);
        acc.wdata = wdata[BYTE_W-1:0];
    end

    // Upper data byte has no storage anywhere in the register set.
    assign unused_hi = ^wdata[DATA_W-1:BYTE_W];

endmodule

// File: rtl/uart_reg_status.sv
// Sticky status words: line status (write-one-to-clear on the error and
// transmit-finished bits) and modem status (write-one-to-clear on the
// clear-to-send-changed bit), plus the receive byte buffer.
// Hardware set strobes take precedence over any clear in the same cycle.
module uart_reg_status
    import uart_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  reg_access_t          acc,
    input  logic [LINE_BITS-1:0] line_set,
    input  logic                 rx_push,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic                 cts_chg,
    input  logic                 cts_level,
    output logic [BYTE_W-1:0]    line_q,
    output logic [BYTE_W-1:0]    modem_q,
    output logic [BYTE_W-1:0]    rx_q
);

    logic                 wr_line;
    logic                 wr_modem;
    logic                 rd_rx;
    logic [LINE_BITS-1:0] line_clr;
    logic [LINE_BITS-1:0] line_hw;
    logic [LINE_BITS-1:0] line_bits;
    logic                 cts_chg_q;
    logic                 cts_q;
    logic                 unused_status;

    // Decode which status operation the current access performs.
    always_comb begin
        wr_line  = acc.valid && acc.we  && (acc.sel == SEL_LINE);
        wr_modem = acc.valid && acc.we  && (acc.sel == SEL_MODEM);
        rd_rx    = acc.valid && !acc.we && (acc.sel == SEL_RX_BUF);
    end

    // Per-bit clear and set requests for the line status word.
    always_comb begin
        line_clr = wr_line ? (acc.wdata[LINE_BITS-1:0] & LINE_W1C_MASK[LINE_BITS-1:0])
                           : '0;
        line_clr[LS_READY] = rd_rx;
        line_hw  = line_set;
        line_hw[LS_READY] = line_set[LS_READY] | rx_push;
    end

    // One sticky flop per line status bit, set wins over clear.
    genvar g;
    generate
        for (g = 0; g < LINE_BITS; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n)              line_bits[g] <= 1'b0;
                else if (line_hw[g])     line_bits[g] <= 1'b1;
                else if (line_clr[g])    line_bits[g] <= 1'b0;
            end
        end
    endgenerate

    // Modem change flag (set wins) and registered clear-to-send level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_chg_q <= 1'b0;
            cts_q     <= 1'b0;
        end else begin
            cts_q <= cts_level;
            if (cts_chg)
                cts_chg_q <= 1'b1;
            else if (wr_modem && acc.wdata[MS_CTS_CHG])
                cts_chg_q <= 1'b0;
        end
    end

    // Receive buffer holds the last byte pushed by the receive path.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_q <= '0;
        else if (rx_push) rx_q <= rx_byte;
    end

    // Assemble the readable status words.
    always_comb begin
        line_q  = {{(BYTE_W-LINE_BITS){1'b0}}, line_bits};
        modem_q = '0;
        modem_q[MS_CTS_CHG] = cts_chg_q;
        modem_q[MS_CTS]     = cts_q;
    end

    // Write data bits above the status fields are never stored.
    assign unused_status = ^acc.wdata[BYTE_W-1:LINE_BITS];

endmodule

// File: rtl/uart_reg_ctrl.sv
// Control storage: interrupt-enable mask reached through set/clear aliases,
// the plain configuration registers, and the transmit hand-off.
// Assumes at most one access per cycle (the decoder guarantees it).
module uart_reg_ctrl
    import uart_regs_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  reg_access_t                       acc,
    output logic [BYTE_W-1:0]                 ie_q,
    output logic [NUM_PLAIN-1:0][BYTE_W-1:0]  plain_q,
    output logic [BYTE_W-1:0]                 tx_hold_q,
    output logic                              tx_load_q,
    output logic                              tx_event_q
);

    logic wr_ie_set;
    logic wr_ie_clr;
    logic wr_tx;

    // Decode the control-side write operations.
    always_comb begin
        wr_ie_set = acc.valid && acc.we && (acc.sel == SEL_IE_SET);
        wr_ie_clr = acc.valid && acc.we && (acc.sel == SEL_IE_CLR);
        wr_tx     = acc.valid && acc.we && (acc.sel == SEL_TX_HOLD);
    end

    // Interrupt-enable mask: OR through one alias, clear-by-one through the other.
    always_ff @(posedge clk) begin
        if (!rst_n)         ie_q <= '0;
        else if (wr_ie_set) ie_q <= ie_q | acc.wdata;
        else if (wr_ie_clr) ie_q <= ie_q & ~acc.wdata;
    end

    // Plain registers: one instance per contiguous selector.
    genvar g;
    generate
        for (g = 0; g < NUM_PLAIN; g++) begin : g_plain
            logic hit;
            assign hit = acc.valid && acc.we &&
                         (acc.sel == reg_sel_e'(SEL_W'(PLAIN_BASE + g)));
            always_ff @(posedge clk) begin
                if (!rst_n)   plain_q[g] <= '0;
                else if (hit) plain_q[g] <= acc.wdata;
            end
        end
    endgenerate

    // Transmit hand-off: latch the byte and pulse load and gated event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold_q  <= '0;
            tx_load_q  <= 1'b0;
            tx_event_q <= 1'b0;
        end else begin
            tx_load_q  <= wr_tx;
            tx_event_q <= wr_tx && ie_q[IE_TX_EMPTY];
            if (wr_tx) tx_hold_q <= acc.wdata;
        end
    end

endmodule

// File: rtl/uart_reg_file.sv
// Top of the serial-port register front end. Decodes host accesses,
// routes them to status and control storage, and returns a registered
// acknowledge/error with read data one cycle after each request.
module uart_reg_file
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [SIZE_W-1:0]     bus_size,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_ack,
    output logic                  bus_err,
    output logic                  bus_err_width,
    output logic [BYTE_W-1:0]     tx_byte,
    output logic                  tx_load,
    output logic                  tx_event,
    input  logic                  rx_push,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic [LINE_BITS-1:0]  stat_line_set,
    input  logic                  stat_cts_chg,
    input  logic                  cts_level,
    output logic [2*BYTE_W-1:0]   cfg_divisor,
    output logic [BYTE_W-1:0]     cfg_gctl,
    output logic [BYTE_W-1:0]     cfg_lcr,
    output logic [BYTE_W-1:0]     cfg_mcr,
    output logic [BYTE_W-1:0]     irq_enable
);

    reg_access_t                      acc;
    logic                             width_err;
    logic                             map_err;
    logic [BYTE_W-1:0]                line_q;
    logic [BYTE_W-1:0]                modem_q;
    logic [BYTE_W-1:0]                rx_q;
    logic [BYTE_W-1:0]                ie_q;
    logic [NUM_PLAIN-1:0][BYTE_W-1:0] plain_q;
    logic [BYTE_W-1:0]                tx_hold_q;
    logic [BYTE_W-1:0]                rd_byte;
    logic                             ack_q;
    logic                             err_q;
    logic                             err_w_q;
    logic [DATA_W-1:0]                rdata_q;

    uart_reg_decode #(
        .ADDR_W       (ADDR_W),
        .SIZE_W       (SIZE_W),
        .ACCESS_BYTES (2)
    ) u_decode (
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .size      (bus_size),
        .wdata     (bus_wdata),
        .acc       (acc),
        .width_err (width_err),
        .map_err   (map_err)
    );

    uart_reg_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .line_set  (stat_line_set),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .cts_chg   (stat_cts_chg),
        .cts_level (cts_level),
        .line_q    (line_q),
        .modem_q   (modem_q),
        .rx_q      (rx_q)
    );

    uart_reg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .ie_q       (ie_q),
        .plain_q    (plain_q),
        .tx_hold_q  (tx_hold_q),
        .tx_load_q  (tx_load),
        .tx_event_q (tx_event)
    );

    // Read multiplexer over every register selector.
    always_comb begin
        rd_byte = '0;
        case (acc.sel)
            SEL_TX_HOLD:            rd_byte = tx_hold_q;
            SEL_RX_BUF:             rd_byte = rx_q;
            SEL_IE_SET, SEL_IE_CLR: rd_byte = ie_q;
            SEL_LINE:               rd_byte = line_q;
            SEL_MODEM:              rd_byte = modem_q;
            default: begin
                for (int g = 0; g < NUM_PLAIN; g++)
                    if (acc.sel == reg_sel_e'(SEL_W'(PLAIN_BASE + g)))
                        rd_byte = plain_q[g];
            end
        endcase
    end

    // Registered response: acknowledge or error, with zero-extended read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            err_w_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= acc.valid;
            err_q   <= width_err || map_err;
            err_w_q <= width_err;
            rdata_q <= (acc.valid && !acc.we) ? {{(DATA_W-BYTE_W){1'b0}}, rd_byte} : '0;
        end
    end

    // Drive the outputs from the stored state.
    always_comb begin
        bus_ack       = ack_q;
        bus_err       = err_q;
        bus_err_width = err_w_q;
        bus_rdata     = rdata_q;
        tx_byte       = tx_hold_q;
        cfg_divisor   = {plain_q[1], plain_q[0]};
        cfg_gctl      = plain_q[2];
        cfg_lcr       = plain_q[3];
        cfg_mcr       = plain_q[4];
        irq_enable    = ie_q;
    end

endmodule

// File: rtl/uart_reg_file_chk.sv
// Property checker for the register front end, bound into the top module.
// Observes the bus, the transmit outputs and the stored status words.
module uart_reg_file_chk #(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SIZE_W-1:0] bus_size,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              bus_err_width,
    input logic [7:0]        tx_byte,
    input logic              tx_load,
    input logic              tx_event,
    input logic [5:0]        stat_line_set,
    input logic              stat_cts_chg,
    input logic [15:0]       cfg_divisor,
    input logic [7:0]        cfg_lcr,
    input logic [7:0]        irq_enable,
    input logic [7:0]        line_q,
    input logic [7:0]        modem_q
);

    logic size_bad;
    logic unmapped;
    logic tx_write;

    // Classify the current request the way the requirements describe it.
    always_comb begin
        size_bad = bus_req && (bus_size != SIZE_W'(2));
        unmapped = (bus_addr[1:0] != 2'b00) || (32'(bus_addr[ADDR_W-1:2]) >= 12);
        tx_write = bus_req && bus_we && (bus_size == SIZE_W'(2)) && (bus_addr == '0);
    end

    AST_WIDTH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        size_bad |=> (bus_err && bus_err_width && !bus_ack)); // R1
    AST_WIDTH_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        size_bad |=> ($stable(cfg_divisor) && $stable(cfg_lcr) && $stable(irq_enable) && !tx_load)); // R1
    AST_WIDTH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (size_bad && unmapped) |=> bus_err_width); // R2
    AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !size_bad && unmapped) |=> (bus_err && !bus_err_width && !bus_ack)); // R3
    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_err)); // R3
    AST_LINE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_line_set != 6'd0) |=> ((line_q[5:0] & $past(stat_line_set)) == $past(stat_line_set))); // R8
    AST_CTS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_cts_chg |=> modem_q[0]); // R8
    AST_TX_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> (tx_load && (tx_byte == $past(bus_wdata[7:0])))); // R9
    AST_EVENT_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_event |-> tx_load); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[15:8] == 8'h00)); // R11

endmodule

bind uart_reg_file uart_reg_file_chk #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_ack       (bus_ack),
    .bus_err       (bus_err),
    .bus_err_width (bus_err_width),
    .tx_byte       (tx_byte),
    .tx_load       (tx_load),
    .tx_event      (tx_event),
    .stat_line_set (stat_line_set),
    .stat_cts_chg  (stat_cts_chg),
    .cfg_divisor   (cfg_divisor),
    .cfg_lcr       (cfg_lcr),
    .irq_enable    (irq_enable),
    .line_q        (line_q),
    .modem_q       (modem_q)
);

// File: tb/uart_reg_file_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the access task queues the expected response, a monitor
// pops it one cycle later and compares it with the bus outputs.
module uart_reg_file_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ack, bus_err, bus_err_width;
    logic [7:0]  tx_byte;
    logic        tx_load, tx_event;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [5:0]  stat_line_set = '0;
    logic        stat_cts_chg = 1'b0;
    logic        cts_level = 1'b0;
    logic [15:0] cfg_divisor;
    logic [7:0]  cfg_gctl, cfg_lcr, cfg_mcr, irq_enable;

    typedef struct {
        bit          ack;
        bit          err;
        bit          errw;
        logic [15:0] rdata;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;

    always #2 clk = ~clk;

    uart_reg_file u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_err_width(bus_err_width), .tx_byte(tx_byte), .tx_load(tx_load),
        .tx_event(tx_event), .rx_push(rx_push), .rx_byte(rx_byte),
        .stat_line_set(stat_line_set), .stat_cts_chg(stat_cts_chg),
        .cts_level(cts_level), .cfg_divisor(cfg_divisor), .cfg_gctl(cfg_gctl),
        .cfg_lcr(cfg_lcr), .cfg_mcr(cfg_mcr), .irq_enable(irq_enable)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one access in the current cycle; strobes set beforehand share it.
    task automatic acc(bit we, logic [7:0] addr, logic [2:0] size, logic [15:0] wd,
                       bit eack, bit eerr, bit eerrw, logic [15:0] erd, string tag);
        exp_t e;
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_size = size; bus_wdata = wd;
        e.ack = eack; e.err = eerr; e.errw = eerrw; e.rdata = erd; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        bus_req = 1'b0; stat_line_set = '0; stat_cts_chg = 1'b0; rx_push = 1'b0;
    endtask

    task automatic wr(logic [7:0] addr, logic [15:0] wd, string tag);
        acc(1'b1, addr, 3'd2, wd, 1'b1, 1'b0, 1'b0, 16'h0000, tag);
    endtask

    task automatic rd(logic [7:0] addr, logic [15:0] erd, string tag);
        acc(1'b0, addr, 3'd2, 16'h0000, 1'b1, 1'b0, 1'b0, erd, tag);
    endtask

    // Monitor: compare the response one cycle after each queued access.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (mon_on) begin
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check({e.tag, " ack"},   32'(bus_ack),       32'(e.ack));
                check({e.tag, " err"},   32'(bus_err),       32'(e.err));
                check({e.tag, " errw"},  32'(bus_err_width), 32'(e.errw));
                check({e.tag, " rdata"}, 32'(bus_rdata),     32'(e.rdata));
            end else if (bus_ack || bus_err) begin
                check("R3 spurious response", 32'({bus_ack, bus_err}), 32'd0);
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R12 reset state
        check("R12 ack", 32'(bus_ack), 0);
        check("R12 err", 32'(bus_err), 0);
        check("R12 divisor", 32'(cfg_divisor), 0);
        check("R12 irq_enable", 32'(irq_enable), 0);
        check("R12 tx_load", 32'(tx_load), 0);
        rd(8'h10, 16'h0000, "R12 line status");
        rd(8'h14, 16'h0000, "R12 modem status");

        // R1 wrong widths, nothing changes
        acc(1'b1, 8'h18, 3'd1, 16'h00AA, 1'b0, 1'b1, 1'b1, 16'h0000, "R1 byte write");
        acc(1'b1, 8'h00, 3'd4, 16'h0077, 1'b0, 1'b1, 1'b1, 16'h0000, "R1 quad tx write");
        check("R1 no tx_load", 32'(tx_load), 0);
        acc(1'b0, 8'h18, 3'd1, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000, "R1 byte read");
        rd(8'h18, 16'h0000, "R1 divisor low unchanged");

        // R2 width beats unmapped
        acc(1'b1, 8'h3C, 3'd4, 16'h1234, 1'b0, 1'b1, 1'b1, 16'h0000, "R2 quad unmapped");
        acc(1'b0, 8'h31, 3'd1, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000, "R2 byte misaligned");

        // R3 unmapped and misaligned
        acc(1'b1, 8'h30, 3'd2, 16'h0055, 1'b0, 1'b1, 1'b0, 16'h0000, "R3 unmapped write");
        acc(1'b0, 8'hFC, 3'd2, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, "R3 unmapped read");
        acc(1'b1, 8'h19, 3'd2, 16'h0055, 1'b0, 1'b1, 1'b0, 16'h0000, "R3 misaligned write");
        rd(8'h18, 16'h0000, "R3 no write landed");

        // R11 plain registers
        wr(8'h18, 16'hAB12, "R11 div low");
        wr(8'h1C, 16'hCD34, "R11 div high");
        rd(8'h18, 16'h0012, "R11 div low read");
        rd(8'h1C, 16'h0034, "R11 div high read");
        check("R11 cfg_divisor", 32'(cfg_divisor), 32'h3412);
        wr(8'h20, 16'h0181, "R11 gctl");
        wr(8'h24, 16'h007E, "R11 lcr");
        wr(8'h28, 16'h0003, "R11 mcr");
        wr(8'h2C, 16'hFFA5, "R11 scratch");
        rd(8'h2C, 16'h00A5, "R11 scratch read");
        check("R11 cfg_gctl", 32'(cfg_gctl), 32'h81);
        check("R11 cfg_lcr", 32'(cfg_lcr), 32'h7E);
        check("R11 cfg_mcr", 32'(cfg_mcr), 32'h03);

        // R4 / R5 enable aliases
        wr(8'h08, 16'h0005, "R4 set 05");
        rd(8'h08, 16'h0005, "R4 read set alias");
        wr(8'h08, 16'h0002, "R4 set 02");
        rd(8'h0C, 16'h0007, "R4 read clear alias");
        check("R4 irq_enable", 32'(irq_enable), 32'h07);
        wr(8'h0C, 16'h0005, "R5 clear 05");
        rd(8'h08, 16'h0002, "R5 remaining mask");

        // R9 transmit hand-off with and without event
        wr(8'h00, 16'h01C5, "R9 tx write enabled");
        check("R9 tx_load", 32'(tx_load), 1);
        check("R9 tx_byte", 32'(tx_byte), 32'hC5);
        check("R9 tx_event", 32'(tx_event), 1);
        @(negedge clk);
        check("R9 tx_load one cycle", 32'(tx_load), 0);
        check("R9 tx_event one cycle", 32'(tx_event), 0);
        wr(8'h0C, 16'h0002, "R9 disable tx irq");
        wr(8'h00, 16'h0033, "R9 tx write disabled");
        check("R9 tx_load 2", 32'(tx_load), 1);
        check("R9 tx_byte 2", 32'(tx_byte), 32'h33);
        check("R9 no tx_event", 32'(tx_event), 0);
        rd(8'h00, 16'h0033, "R9 tx hold read");

        // R10 receive buffer
        rx_byte = 8'h5A; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        rd(8'h10, 16'h0001, "R10 data ready set");
        wr(8'h04, 16'h00FF, "R10 write ignored");
        rd(8'h04, 16'h005A, "R10 rx byte");
        rd(8'h10, 16'h0000, "R10 data ready cleared");

        // R6 line status write-one-to-clear
        stat_line_set = 6'h3E; rx_byte = 8'h11; rx_push = 1'b1;
        @(negedge clk);
        stat_line_set = '0; rx_push = 1'b0;
        rd(8'h10, 16'h003F, "R6 all set");
        wr(8'h10, 16'h000C, "R6 clear parity framing");
        rd(8'h10, 16'h0033, "R6 partial clear");
        wr(8'h10, 16'hFFFF, "R6 clear all");
        rd(8'h10, 16'h0001, "R6 data ready kept");
        rd(8'h04, 16'h0011, "R10 drain");
        rd(8'h10, 16'h0000, "R10 drained");

        // R8 set beats clear in the same cycle (line)
        stat_line_set = 6'h04;
        wr(8'h10, 16'h0004, "R8 line collide");
        rd(8'h10, 16'h0004, "R8 line bit kept");
        stat_line_set = 6'h02;
        wr(8'h10, 16'h0006, "R8 line mixed");
        rd(8'h10, 16'h0002, "R8 strobed kept other cleared");

        // R7 modem status
        cts_level = 1'b1; stat_cts_chg = 1'b1;
        @(negedge clk);
        stat_cts_chg = 1'b0;
        rd(8'h14, 16'h0011, "R7 change and level");
        wr(8'h14, 16'hFFFF, "R7 clear");
        rd(8'h14, 16'h0010, "R7 level only");
        stat_cts_chg = 1'b1;
        wr(8'h14, 16'h0001, "R8 modem collide");
        rd(8'h14, 16'h0011, "R8 modem change kept");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule